// File: doc/BRIEF.md
# Preemptive Conversion Request Scheduler

This block decides which of two kinds of conversion uses a single shared filter datapath. Urgent conversions come from a software start pulse or an external trigger pulse. Background conversions come from a software start pulse. Background conversions can run once or repeat while a continuous-mode level is held. The scheduler sends start and abort strobes to a conversion engine, together with a kind bit. It receives the engine's completion pulse and reports each finished result as urgent or background.

An urgent request that arrives while a background conversion runs aborts that conversion and takes the datapath at once. When the urgent conversion completes, the interrupted background conversion is started again. A background start that arrives while an urgent conversion runs is held until the urgent conversion completes. In both cases the first background result after the delay carries a delayed-start flag. Requests that arrive together, and requests waiting at a completion, are resolved by fixed precedence: urgent first. The filter enable is low whenever neither kind of conversion is busy.

Top module: `conv_arbiter`

## Requirements
- R1: While `inj_busy` is 1, pulses on `inj_sw_start` or `inj_trig` are ignored: no urgent start is issued and the busy flags are unchanged.
- R2: While `reg_busy` is 1, a pulse on `reg_sw_start` is ignored. This includes the time the background conversion is preempted or waiting to restart.
- R3: An accepted urgent request during a running background conversion raises `eng_abort` for exactly one cycle. This is the same cycle as `eng_start` with `eng_kind`=1. If the background conversion completes in that same cycle, no abort is raised.
- R4: After an interrupted background conversion, the urgent completion relaunches it: `eng_start` with `eng_kind`=0 follows one cycle after that `eng_done`. Its result is flagged with `res_dly`=1.
- R5: An interrupted background conversion that was in continuous mode is relaunched only if `reg_cont` is still 1 at the urgent completion. Otherwise it is dropped and `reg_busy` falls.
- R6: A background start accepted while an urgent conversion runs is queued. It is launched one cycle after the urgent `eng_done`, and its result has `res_dly`=1.
- R7: If urgent and background requests arrive in the same cycle while idle, the urgent conversion starts first and the background conversion runs after it.
- R8: `res_dly` is 1 on exactly one background result, the first after a delayed start. Later results in a continuous run carry 0.
- R9: `filt_en` is 1 exactly when `inj_busy` or `reg_busy` is 1.
- R10: When a background conversion completes with `reg_cont`=1, the next conversion starts in the following cycle. With `reg_cont`=0, `reg_busy` falls.
- R11: All outputs are registered. `eng_start` is a one-cycle pulse one cycle after the accepting input, and `eng_kind` is 1 for urgent and 0 for background. `res_inj` and `res_reg` pulse one cycle after `eng_done`. `eng_done` while idle is ignored.
- R12: During and after reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inj_sw_start | input | 1 | Software request pulse for an urgent conversion |
| inj_trig | input | 1 | External trigger pulse for an urgent conversion |
| reg_sw_start | input | 1 | Software request pulse for a background conversion |
| reg_cont | input | 1 | Continuous-mode level for background conversions |
| eng_done | input | 1 | Engine completion pulse for the current conversion |
| eng_start | output | 1 | Start strobe to the engine |
| eng_kind | output | 1 | Kind of the started conversion: 1 urgent, 0 background |
| eng_abort | output | 1 | Abort strobe for the running background conversion |
| inj_busy | output | 1 | Urgent conversion in progress |
| reg_busy | output | 1 | Background conversion in progress, preempted or queued |
| res_inj | output | 1 | Urgent result delivered |
| res_reg | output | 1 | Background result delivered |
| res_dly | output | 1 | Delayed-start flag, valid with `res_reg` |
| filt_en | output | 1 | Filter and integrator enable |

## Verification
A lost queued or interrupted background conversion shows up one cycle after the urgent `eng_done`: `eng_start` stays low while `reg_busy` stays high, and the filter never goes idle. A delayed-start flag that is cleared or left set wrongly shows on the first or second background result after the restart. A busy flag that does not block new requests shows in the next cycle as an extra urgent start or a spurious abort. The same-cycle collisions, such as a request arriving together with a completion, are the cases most likely to hide a wrong precedence, so each of them is driven directly.

// File: rtl/conv_arbiter.sv
module conv_arbiter (
  input  logic clk,
  input  logic rst_n,
  input  logic inj_sw_start,
  input  logic inj_trig,
  input  logic reg_sw_start,
  input  logic reg_cont,
  input  logic eng_done,
  output logic eng_start,
  output logic eng_kind,
  output logic eng_abort,
  output logic inj_busy,
  output logic reg_busy,
  output logic res_inj,
  output logic res_reg,
  output logic res_dly,
  output logic filt_en
);

  typedef enum logic [1:0] {S_IDLE, S_INJ, S_REG} st_t;

  st_t  st, st_n;
  logic pend, pend_n, icont, icont_n, dly, dly_n;
  logic ib_n, rb_n, start_n, kind_n, abort_n;

  wire inj_acc = (inj_sw_start | inj_trig) & ~inj_busy;
  wire reg_acc = reg_sw_start & ~reg_busy;
  wire inj_fin = eng_done & (st == S_INJ);
  wire reg_fin = eng_done & (st == S_REG);

  assign filt_en = inj_busy | reg_busy;

  always_comb begin
    st_n    = st;
    pend_n  = pend;
    icont_n = icont;
    dly_n   = dly;
    ib_n    = inj_busy;
    rb_n    = reg_busy;
    start_n = 1'b0;
    kind_n  = eng_kind;
    abort_n = 1'b0;
    if (inj_acc) begin
      st_n    = S_INJ;
      ib_n    = 1'b1;
      start_n = 1'b1;
      kind_n  = 1'b1;
      if (st == S_REG) begin
        if (reg_fin) begin
          if (reg_cont) begin
            pend_n  = 1'b1;
            icont_n = 1'b0;
            dly_n   = 1'b1;
          end else begin
            rb_n  = 1'b0;
            dly_n = 1'b0;
          end
        end else begin
          abort_n = 1'b1;
          pend_n  = 1'b1;
          icont_n = reg_cont;
          dly_n   = 1'b1;
        end
      end
      if (reg_acc) begin
        rb_n    = 1'b1;
        pend_n  = 1'b1;
        icont_n = 1'b0;
        dly_n   = 1'b1;
      end
    end else if (inj_fin) begin
      ib_n = 1'b0;
      if (reg_acc) begin
        rb_n    = 1'b1;
        dly_n   = 1'b1;
        st_n    = S_REG;
        start_n = 1'b1;
        kind_n  = 1'b0;
      end else if (pend) begin
        pend_n = 1'b0;
        if (icont && !reg_cont) begin
          rb_n  = 1'b0;
          dly_n = 1'b0;
          st_n  = S_IDLE;
        end else begin
          st_n    = S_REG;
          start_n = 1'b1;
          kind_n  = 1'b0;
        end
      end else begin
        st_n = S_IDLE;
      end
    end else if (reg_fin) begin
      dly_n = 1'b0;
      if (reg_cont) begin
        start_n = 1'b1;
        kind_n  = 1'b0;
      end else begin
        rb_n = 1'b0;
        st_n = S_IDLE;
      end
    end else if (reg_acc) begin
      rb_n = 1'b1;
      if (inj_busy) begin
        pend_n  = 1'b1;
        icont_n = 1'b0;
        dly_n   = 1'b1;
      end else begin
        st_n    = S_REG;
        start_n = 1'b1;
        kind_n  = 1'b0;
        dly_n   = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      pend      <= 1'b0;
      icont     <= 1'b0;
      dly       <= 1'b0;
      inj_busy  <= 1'b0;
      reg_busy  <= 1'b0;
      eng_start <= 1'b0;
      eng_kind  <= 1'b0;
      eng_abort <= 1'b0;
      res_inj   <= 1'b0;
      res_reg   <= 1'b0;
      res_dly   <= 1'b0;
    end else begin
      st        <= st_n;
      pend      <= pend_n;
      icont     <= icont_n;
      dly       <= dly_n;
      inj_busy  <= ib_n;
      reg_busy  <= rb_n;
      eng_start <= start_n;
      eng_kind  <= kind_n;
      eng_abort <= abort_n;
      res_inj   <= inj_fin;
      res_reg   <= reg_fin;
      res_dly   <= reg_fin & dly;
    end
  end

endmodule

// File: rtl/conv_arbiter_chk.sv
module conv_arbiter_chk (
  input logic clk,
  input logic rst_n,
  input logic inj_sw_start,
  input logic inj_trig,
  input logic reg_sw_start,
  input logic reg_cont,
  input logic eng_done,
  input logic eng_start,
  input logic eng_kind,
  input logic eng_abort,
  input logic inj_busy,
  input logic reg_busy,
  input logic res_inj,
  input logic res_reg,
  input logic res_dly,
  input logic filt_en
);

  a_r3_abort_with_inj_start: assert property (@(posedge clk) disable iff (!rst_n)
    eng_abort |-> (eng_start && eng_kind));

  a_r3_abort_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    eng_abort |=> !eng_abort);

  a_r3_abort_needs_reg: assert property (@(posedge clk) disable iff (!rst_n)
    eng_abort |-> $past(reg_busy));

  a_r1_inj_held: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_busy && !eng_done) |=> (inj_busy && !(eng_start && eng_kind)));

  a_r8_dly_once: assert property (@(posedge clk) disable iff (!rst_n)
    (res_reg && res_dly) |=> !res_dly);

  a_r8_dly_with_result: assert property (@(posedge clk) disable iff (!rst_n)
    res_dly |-> res_reg);

  a_r11_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> filt_en);

  a_r9_idle_no_result: assert property (@(posedge clk) disable iff (!rst_n)
    !filt_en |=> !eng_abort);

endmodule

bind conv_arbiter conv_arbiter_chk u_chk (.*);

// File: tb/sim_conv_arbiter.sv
module sim_conv_arbiter;
  localparam int PERIOD = 10;
  localparam int NV = 29;
  // {isw,itr,rsw,cont,done} , {start,kind,abort,ibusy,rbusy,rinj,rreg,rdly,fen}
  localparam logic [13:0] VEC [NV] = '{
    {5'b00100, 9'b100010001}, {5'b00000, 9'b000010001}, {5'b01000, 9'b111110001},
    {5'b10100, 9'b010110001}, {5'b00001, 9'b100011001}, {5'b00001, 9'b000000110},
    {5'b00000, 9'b000000000}, {5'b10100, 9'b110110001}, {5'b00001, 9'b100011001},
    {5'b00011, 9'b100010111}, {5'b00011, 9'b100010101}, {5'b01010, 9'b111110001},
    {5'b00000, 9'b010110001}, {5'b00001, 9'b010001000}, {5'b00010, 9'b010000000},
    {5'b00110, 9'b100010001}, {5'b10010, 9'b111110001}, {5'b00011, 9'b100011001},
    {5'b00011, 9'b100010111}, {5'b00001, 9'b000000100}, {5'b01000, 9'b110100001},
    {5'b00100, 9'b010110001}, {5'b00001, 9'b100011001}, {5'b00001, 9'b000000110},
    {5'b00110, 9'b100010001}, {5'b01011, 9'b110110101}, {5'b00001, 9'b100011001},
    {5'b00001, 9'b000000110}, {5'b00001, 9'b000000000}
  };

  logic clk = 0, rst_n = 0;
  logic inj_sw_start = 0, inj_trig = 0, reg_sw_start = 0, reg_cont = 0, eng_done = 0;
  logic eng_start, eng_kind, eng_abort, inj_busy, reg_busy, res_inj, res_reg, res_dly, filt_en;
  int n_chk = 0, n_bad = 0;
  bit fin = 0;

  always #(PERIOD/2) clk = ~clk;

  conv_arbiter u0 (.*);

  function automatic string tag_of(int i);
    case (i)
      0, 1, 28: return "R11";
      2, 11, 16, 25: return "R3";
      3: return "R1 R2";
      4: return "R4";
      5: return "R4 R8";
      7, 8: return "R7";
      9: return "R8 R10";
      10, 18, 27: return "R8";
      12: return "R2";
      13, 14: return "R5";
      15, 19, 24: return "R10";
      17: return "R5 R4";
      20: return "R1";
      21, 22, 23, 26: return "R6";
      default: return "R9";
    endcase
  endfunction

  task automatic check(string tag, logic [8:0] exp);
    logic [8:0] got;
    got = {eng_start, eng_kind, eng_abort, inj_busy, reg_busy, res_inj, res_reg, res_dly, filt_en};
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic drive(logic [4:0] v);
    {inj_sw_start, inj_trig, reg_sw_start, reg_cont, eng_done} = v;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!fin) begin
      fin = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk); @(negedge clk);
    check("R12 reset", 9'b0);
    rst_n = 1;
    @(negedge clk);
    check("R12 after reset", 9'b0);
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][13:9]);
      check(tag_of(i), VEC[i][8:0]);
    end
    // R6: background request in the same cycle as the urgent completion
    drive(5'b01000); check("R1 setup", 9'b110100001);
    drive(5'b00101); check("R6 same-cycle", 9'b100011001);
    drive(5'b00001); check("R8 same-cycle", 9'b000000110);
    // R12: reset while busy
    drive(5'b01100); check("R7 setup", 9'b110110001);
    rst_n = 0;
    @(negedge clk);
    check("R12 mid-run", 9'b0);
    rst_n = 1;
    drive(5'b00000); check("R12 stays idle", 9'b0);
    finish_run();
  end
endmodule